// File: doc/BRIEF.md
# Trap and Call Dispatch Unit

This block sits between a processor's exception logic and its service firmware. Each cycle it may receive one raised exception index. It sorts that index into one of three kinds: a fixed fault cause, a software call trap, or an impossible index. It then produces the vector of the service routine that should run next. The low indices name the fixed fault causes directly. Two higher windows of indices carry software call traps. Both windows fold into one 8-bit function code: the low window yields codes 0x00 to 0x7F and the high window yields codes 0x80 to 0xFF.

Codes below 0x80 are restricted. They are honoured only when the mode field of the status input (status shifted right by three) is zero. Otherwise the unit returns a privilege-fault vector and leaves all of its state alone. One restricted code, the swap code, changes the active handler set. A small operand selects a built-in set that the set-valid input marks as present. A large operand is taken as a raw entry address, which is loaded into both the base register and the program counter.

Every dispatch also captures the faulting address with bit 0 forced low. The result appears one cycle after the strobe.

Top module: `tdisp_top`

## Requirements
- R1: Indices 0 to 11 are fixed causes, in this order: reset, machine check, arithmetic, interrupt, data fault, data miss in the privileged context, data miss in native mode, unaligned, instruction miss, instruction access violation, illegal opcode, FP disabled. For each of them, vec_id equals the index and fn_code is 0.
- R2: An index in [0x2000, 0x4000) gives vec_id 16 (call) with fn_code = (index − 0x2000) >> 6, provided the privilege rule allows it.
- R3: An index in [0x4000, 0x6000) gives vec_id 16 with fn_code = ((index − 0x4000) >> 6) + 0x80. Such a code is never refused.
- R4: Any other index (12 to 0x1FFF, or 0x6000 and above) gives vec_id 18 (internal error) and changes no state.
- R5: A function code below 0x80 while status>>3 is nonzero gives vec_id 17 (privilege fault). It changes no set, base or PC, even when the code is the swap code.
- R6: Swap code 0x0A with an operand below 3 whose set_valid bit is 1 sets active_set to the operand, sets base_q to all ones, and gives vec_id 0 (that set's reset entry).
- R7: Swap code 0x0A with an operand of 256 or more sets active_set to 3 (none) and loads the operand into both base_q and pc_q. It gives vec_id 19 and pulses pc_load for one cycle.
- R8: Swap code 0x0A with an operand below 256 that names no valid set gives vec_id 20, pulses swap_fail, and leaves active_set, base_q and pc_q unchanged.
- R9: After every dispatch, exc_addr_q equals the exc_addr_in presented with the strobe, with bit 0 cleared.
- R10: vec_valid is high in the cycle after an exc_valid strobe and low otherwise.
- R11: After reset, vec_valid, pc_load and swap_fail are 0, active_set is 0, base_q is all ones, and pc_q and exc_addr_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception strobe |
| exc_index | input | 16 | Raised exception or trap index |
| status | input | 8 | Processor status; bits [7:3] are the mode field |
| call_operand | input | 32 | Operand of the call (swap id or entry address) |
| exc_addr_in | input | 32 | Faulting address to save |
| set_valid | input | 3 | Built-in handler sets that are present |
| vec_valid | output | 1 | Dispatch result valid |
| vec_id | output | 5 | Target vector |
| fn_code | output | 8 | Folded call function code |
| active_set | output | 2 | Active handler-set id, 3 = none |
| base_q | output | 32 | Handler base register |
| pc_q | output | 32 | New program counter |
| pc_load | output | 1 | pc_q was loaded by this dispatch |
| swap_fail | output | 1 | Swap named an unknown set |
| exc_addr_q | output | 32 | Saved exception address |

## Verification
A wrong fold or a wrong window bound shows as a wrong fn_code or vec_id in the first cycle after the strobe. That is the next comparison against the bench model. A privilege or swap fault that corrupts active_set, base_q or pc_q is worse, because those registers persist. The bench compares them on every clock, so a bad update is reported in the cycle it lands, not when a later dispatch would use it. Probes sit at each window edge, at a refused swap, and at an invalid set id, because a single wrong compare there changes state without any other visible sign.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
  typedef enum logic [1:0] {K_FIXED, K_CALL, K_BAD} kind_e;

  localparam int unsigned N_FIXED  = 12;
  localparam logic [4:0] VEC_SETRST = 5'd0;
  localparam logic [4:0] VEC_CALL   = 5'd16;
  localparam logic [4:0] VEC_PRIV   = 5'd17;
  localparam logic [4:0] VEC_BAD    = 5'd18;
  localparam logic [4:0] VEC_ENTRY  = 5'd19;
  localparam logic [4:0] VEC_SWFAIL = 5'd20;

  // Fold an offset inside a call window into a function code.
  function automatic logic [7:0] fold_code(input logic [31:0] off, input logic high_half);
    logic [31:0] s;
    s = off >> 6;
    return 8'(s) + (high_half ? 8'h80 : 8'h00);
  endfunction

  // Restricted codes need mode field (status >> 3) equal to zero.
  function automatic logic needs_kernel(input logic [7:0] code);
    return code < 8'h80;
  endfunction
endpackage

// File: rtl/tdisp_classify.sv
module tdisp_classify
  import tdisp_pkg::*;
#(
  parameter int unsigned IDX_W   = 16,
  parameter int unsigned LO_BASE = 32'h2000,
  parameter int unsigned HI_BASE = 32'h4000,
  parameter int unsigned HI_END  = 32'h6000
) (
  input  logic [IDX_W-1:0] idx,
  output kind_e            kind,
  output logic [7:0]       code
);
  logic [31:0] wide_idx;
  assign wide_idx = 32'(idx);

  always_comb begin
    kind = K_BAD;
    code = 8'h00;
    if (wide_idx < N_FIXED) begin
      kind = K_FIXED;
    end else if (wide_idx >= LO_BASE && wide_idx < HI_BASE) begin
      kind = K_CALL;
      code = fold_code(wide_idx - LO_BASE, 1'b0);
    end else if (wide_idx >= HI_BASE && wide_idx < HI_END) begin
      kind = K_CALL;
      code = fold_code(wide_idx - HI_BASE, 1'b1);
    end
  end
endmodule

// File: rtl/tdisp_priv_gate.sv
module tdisp_priv_gate
  import tdisp_pkg::*;
#(
  parameter int unsigned ST_W = 8
) (
  input  logic            is_call,
  input  logic [7:0]      code,
  input  logic [ST_W-1:0] status,
  output logic            deny
);
  logic [ST_W-1:0] mode_field;
  assign mode_field = status >> 3;
  assign deny = is_call && needs_kernel(code) && (mode_field != '0);
endmodule

// File: rtl/tdisp_swap.sv
module tdisp_swap #(
  parameter int unsigned OP_W      = 32,
  parameter int unsigned NSETS     = 3,
  parameter int unsigned ID_W      = 2,
  parameter int unsigned SMALL_LIM = 256
) (
  input  logic [OP_W-1:0]  operand,
  input  logic [NSETS-1:0] set_valid,
  output logic             sw_entry,
  output logic             sw_fail,
  output logic [ID_W-1:0]  sw_set,
  output logic [OP_W-1:0]  sw_base
);
  localparam logic [ID_W-1:0] SET_NONE = ID_W'(NSETS);

  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSETS; i++) begin
      if (operand == OP_W'(i) && set_valid[i]) hit = 1'b1;
    end
  end

  assign sw_entry = (operand >= OP_W'(SMALL_LIM));
  assign sw_fail  = !sw_entry && !hit;
  assign sw_set   = sw_entry ? SET_NONE : ID_W'(operand);
  assign sw_base  = sw_entry ? operand : '1;
endmodule

// File: rtl/tdisp_top.sv
module tdisp_top
  import tdisp_pkg::*;
#(
  parameter int unsigned IDX_W   = 16,
  parameter int unsigned ST_W    = 8,
  parameter int unsigned OP_W    = 32,
  parameter int unsigned NSETS   = 3,
  parameter int unsigned ID_W    = $clog2(NSETS + 1),
  parameter logic [7:0]  SWAP_FN = 8'h0A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic [IDX_W-1:0] exc_index,
  input  logic [ST_W-1:0]  status,
  input  logic [OP_W-1:0]  call_operand,
  input  logic [OP_W-1:0]  exc_addr_in,
  input  logic [NSETS-1:0] set_valid,
  output logic             vec_valid,
  output logic [4:0]       vec_id,
  output logic [7:0]       fn_code,
  output logic [ID_W-1:0]  active_set,
  output logic [OP_W-1:0]  base_q,
  output logic [OP_W-1:0]  pc_q,
  output logic             pc_load,
  output logic             swap_fail,
  output logic [OP_W-1:0]  exc_addr_q
);
  localparam logic [ID_W-1:0] SET_NONE = ID_W'(NSETS);

  kind_e           cls_kind;
  logic [7:0]      cls_code;
  logic            priv_deny;
  logic            sw_entry, sw_fail;
  logic [ID_W-1:0] sw_set;
  logic [OP_W-1:0] sw_base;

  tdisp_classify #(.IDX_W(IDX_W)) u_cls (
    .idx(exc_index), .kind(cls_kind), .code(cls_code));

  tdisp_priv_gate #(.ST_W(ST_W)) u_gate (
    .is_call(cls_kind == K_CALL), .code(cls_code), .status(status), .deny(priv_deny));

  tdisp_swap #(.OP_W(OP_W), .NSETS(NSETS), .ID_W(ID_W)) u_swap (
    .operand(call_operand), .set_valid(set_valid),
    .sw_entry(sw_entry), .sw_fail(sw_fail), .sw_set(sw_set), .sw_base(sw_base));

  // Named events for the assertions
  logic ev_call_ok, ev_swap_go;
  assign ev_call_ok = exc_valid && (cls_kind == K_CALL) && !priv_deny;
  assign ev_swap_go = ev_call_ok && (cls_code == SWAP_FN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid  <= 1'b0;
      vec_id     <= '0;
      fn_code    <= '0;
      active_set <= '0;
      base_q     <= '1;
      pc_q       <= '0;
      pc_load    <= 1'b0;
      swap_fail  <= 1'b0;
      exc_addr_q <= '0;
    end else begin
      vec_valid <= exc_valid;
      pc_load   <= 1'b0;
      swap_fail <= 1'b0;
      if (exc_valid) begin
        exc_addr_q <= exc_addr_in & ~OP_W'(1);
        fn_code    <= cls_code;
        if (cls_kind == K_FIXED) begin
          vec_id <= 5'(exc_index);
        end else if (cls_kind == K_BAD) begin
          vec_id <= VEC_BAD;
        end else if (priv_deny) begin
          vec_id <= VEC_PRIV;
        end else if (ev_swap_go) begin
          if (sw_fail) begin
            vec_id    <= VEC_SWFAIL;
            swap_fail <= 1'b1;
          end else begin
            active_set <= sw_set;
            base_q     <= sw_base;
            if (sw_entry) begin
              vec_id  <= VEC_ENTRY;
              pc_q    <= call_operand;
              pc_load <= 1'b1;
            end else begin
              vec_id <= VEC_SETRST;
            end
          end
        end else begin
          vec_id <= VEC_CALL;
        end
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(exc_valid)); // R10
  AST_ADDR_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (exc_addr_q == ($past(exc_addr_in) & ~OP_W'(1)))); // R9
  AST_PRIV_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_id == VEC_PRIV) |-> ($stable(active_set) && $stable(base_q) && $stable(pc_q))); // R5
  AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_q == base_q && active_set == SET_NONE && vec_id == VEC_ENTRY)); // R7
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fail |-> ($stable(active_set) && $stable(base_q) && $stable(pc_q))); // R8
  AST_KNOWN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_id == VEC_SETRST && $past(ev_swap_go)) |-> (base_q == '1 && active_set < SET_NONE)); // R6
endmodule

// File: tb/tdisp_top_tb_top.sv
`timescale 1ns/1ps
module tdisp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [15:0] exc_index = '0;
  logic [7:0]  status = '0;
  logic [31:0] call_operand = '0;
  logic [31:0] exc_addr_in = '0;
  logic [2:0]  set_valid = 3'b011;
  logic        vec_valid, pc_load, swap_fail;
  logic [4:0]  vec_id;
  logic [7:0]  fn_code;
  logic [1:0]  active_set;
  logic [31:0] base_q, pc_q, exc_addr_q;

  always #10 clk = ~clk;

  tdisp_top dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_index(exc_index),
    .status(status), .call_operand(call_operand), .exc_addr_in(exc_addr_in),
    .set_valid(set_valid), .vec_valid(vec_valid), .vec_id(vec_id), .fn_code(fn_code),
    .active_set(active_set), .base_q(base_q), .pc_q(pc_q), .pc_load(pc_load),
    .swap_fail(swap_fail), .exc_addr_q(exc_addr_q));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          m_vv, m_pcl, m_sf;
  int unsigned m_vec, m_code, m_set, m_base, m_pc, m_addr;
  string       m_tag = "R11";
  string       s_tag = "R11";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vv = 0; m_pcl = 0; m_sf = 0; m_vec = 0; m_code = 0;
      m_set = 0; m_base = 32'hFFFF_FFFF; m_pc = 0; m_addr = 0;
    end else begin
      int unsigned ix;
      bit is_call;
      ix = exc_index;
      m_vv = exc_valid; m_pcl = 0; m_sf = 0;
      if (exc_valid) begin
        is_call = 0;
        m_addr = exc_addr_in - (exc_addr_in % 2);
        m_code = 0;
        if (ix <= 11) begin m_vec = ix; m_tag = "R1"; end
        else if (ix >= 'h2000 && ix < 'h4000) begin m_code = (ix - 'h2000) / 64; is_call = 1; m_tag = "R2"; end
        else if (ix >= 'h4000 && ix < 'h6000) begin m_code = (ix - 'h4000) / 64 + 128; is_call = 1; m_tag = "R3"; end
        else begin m_vec = 18; m_tag = "R4"; end
        if (is_call) begin
          if (m_code < 128 && status / 8 != 0) begin m_vec = 17; m_tag = "R5"; end
          else if (m_code == 10) begin
            if (call_operand >= 256) begin
              m_set = 3; m_base = call_operand; m_pc = call_operand; m_pcl = 1; m_vec = 19; m_tag = "R7";
            end else if (call_operand < 3 && set_valid[call_operand[1:0]]) begin
              m_set = call_operand; m_base = 32'hFFFF_FFFF; m_vec = 0; m_tag = "R6";
            end else begin
              m_sf = 1; m_vec = 20; m_tag = "R8";
            end
            s_tag = m_tag;
          end else m_vec = 16;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10", "vec_valid", vec_valid, m_vv);
      chk(s_tag, "active_set", active_set, m_set);
      chk(s_tag, "base_q", base_q, m_base);
      chk(s_tag, "pc_q", pc_q, m_pc);
      chk("R7", "pc_load", pc_load, m_pcl);
      chk("R8", "swap_fail", swap_fail, m_sf);
      if (m_vv) begin
        chk(m_tag, "vec_id", vec_id, m_vec);
        chk(m_tag, "fn_code", fn_code, m_code);
        chk("R9", "exc_addr_q", exc_addr_q, m_addr);
      end
    end
  end

  task automatic fire(int unsigned ix, int unsigned st, int unsigned op, int unsigned addr);
    @(negedge clk);
    exc_valid = 1; exc_index = 16'(ix); status = 8'(st);
    call_operand = op; exc_addr_in = addr;
    @(negedge clk);
    exc_valid = 0;
  endtask

  task automatic fire_b2b(int unsigned ix, int unsigned addr);
    @(negedge clk);
    exc_valid = 1; exc_index = 16'(ix); status = 0; exc_addr_in = addr;
  endtask

  localparam int unsigned SWAP_IX = 'h2000 + 10 * 64;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R11", "reset vec_valid", vec_valid, 0);
    chk("R11", "reset active_set", active_set, 0);
    chk("R11", "reset base_q", base_q, 32'hFFFF_FFFF);
    chk("R11", "reset pc_q", pc_q, 0);
    chk("R11", "reset exc_addr_q", exc_addr_q, 0);
    for (int i = 0; i < 12; i++) fire(i, 8'h18, 0, 32'h100 + i);     // R1
    fire('h2000, 0, 0, 32'h11);                                     // R2 code 0
    fire('h2040 + 5, 0, 0, 32'h13);                                 // R2 code 1
    fire('h3FFF, 0, 0, 32'h21);                                     // R2 code 0x7F
    fire('h4000, 8'h18, 0, 32'h23);                                 // R3 code 0x80
    fire('h5FFF, 8'hF8, 0, 32'h25);                                 // R3 code 0xFF
    fire('h2000 + 7 * 64, 8'h08, 0, 32'h27);                        // R5
    fire(12, 0, 0, 1);                                              // R4
    fire('h1FFF, 0, 0, 3);                                          // R4
    fire('h6000, 0, 0, 5);                                          // R4
    fire('hFFFF, 0, 0, 7);                                          // R4
    fire(SWAP_IX, 0, 1, 32'h31);                                    // R6 set 1
    fire(SWAP_IX, 0, 2, 32'h33);                                    // R8 set 2 absent
    fire(SWAP_IX, 0, 5, 32'h35);                                    // R8 unknown id
    fire(SWAP_IX, 0, 255, 32'h37);                                  // R8 boundary
    fire(SWAP_IX, 0, 256, 32'h39);                                  // R7 boundary
    fire(SWAP_IX, 8'h08, 32'h8000_0000, 32'h41);                    // R5 refused swap
    fire(SWAP_IX, 0, 32'h0012_3400, 32'h43);                        // R7
    set_valid = 3'b111;
    fire(SWAP_IX, 0, 2, 32'h45);                                    // R6 set 2
    fire(SWAP_IX + 'h2000, 0, 0, 32'h47);                           // R3 code 0x8A is not swap
    fire_b2b(3, 32'h51); fire_b2b('h2080, 32'h53); fire_b2b(SWAP_IX, 32'h55); // R10 back to back
    @(negedge clk); exc_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule